// File: doc/BRIEF.md
# Dual-Lane Signed Halfword Multiply-Accumulate Unit

This execution unit carries out one packed multiply-accumulate instruction against a private bank of sixteen 32-bit media registers. Each source register holds two signed 16-bit halves. A 2-bit operand pattern chooses which halves are paired, and the unit forms two signed 16x16 products from those pairs. A second 2-bit pattern decides, for each lane, whether its product is added to or subtracted from an accumulator register. The left lane accumulates into one register and the right lane into another. Both results are written back on the same clock edge.

The instruction arrives as a 32-bit word with a valid strobe. A recognised word updates the bank at the next rising edge, and `done` is high for the one cycle after that edge. Words that do not match the encoding are dropped. A load port writes any register directly, and two combinational peek ports read any register. Together these let a surrounding pipeline or a testbench set up operands and inspect results.

Top module: `simd16_mac`

## Requirements
- R1: A word is executed only when `issue_valid` is high, bits 31:26 equal 6'h1C and bits 5:0 equal 6'h0A. Any other word, or a matching word with `issue_valid` low, changes no register and produces no `done`.
- R2: `done` is high for exactly the one cycle after each edge at which a recognised word was accepted, and low otherwise.
- R3: The left accumulator index is bits 9:6, the first source B is bits 13:10, the second source C is bits 17:14, the right accumulator index is bits 21:18, the operand pattern is bits 23:22 and the accumulate pattern is bits 25:24.
- R4: The upper half of a source is bits 31:16 and the lower half is bits 15:0. Both halves are treated as signed two's-complement values (for example 0x8000 * 0x8000 = 0x40000000).
- R5: The operand pattern selects the left product as B.hi*C.hi for 0, B.lo*C.hi for 1, B.hi*C.hi for 2 and B.lo*C.hi for 3. It selects the right product as B.lo*C.lo for 0, B.lo*C.lo for 1, B.hi*C.lo for 2 and B.hi*C.lo for 3.
- R6: Accumulate pattern bit 1 set makes the left lane subtract, and bit 0 set makes the right lane subtract. Otherwise each lane adds, so 0 adds in both lanes, 1 subtracts on the right only, 2 subtracts on the left only and 3 subtracts in both.
- R7: Both lanes use the register contents from before the edge, even when an accumulator is also a source.
- R8: Sums and differences wrap modulo 2^32, with no saturation.
- R9: Register 0 always reads as zero. Instruction writes and load writes to index 0 are discarded.
- R10: When the two accumulator indices are equal, that register receives the right-lane result.
- R11: While `rst_n` is low at a rising edge, every register is cleared and `done` goes low.
- R12: With `load_en` high, `load_data` is written to register `load_idx` at the edge. An instruction write to the same register at that edge takes precedence. Each peek port returns the current contents of the register it names, with no delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | Instruction word is presented this cycle |
| issue_word | input | 32 | Instruction word |
| done | output | 1 | One-cycle completion pulse |
| load_en | input | 1 | Direct register write enable |
| load_idx | input | 4 | Register written by the load port |
| load_data | input | 32 | Value written by the load port |
| peek_idx | input | 8 | Two packed 4-bit register indices to observe |
| peek_data | output | 64 | Two packed 32-bit register contents, port 0 in the low word |

## Verification
The assertions check the completion handshake against the decoded strobe on every cycle. They compare both lane results with an independent per-pattern calculation whenever an instruction is accepted, and they confirm that each winning write lands in its register one edge later, which covers equal accumulator indices and load collisions. Only the bench scenarios can show the architectural effect over time. Those scenarios cover accumulation that chains across successive instructions, the use of old values when accumulators double as sources, wrap-around at the 32-bit limits, and the fact that ignored words and writes to register 0 leave the whole bank untouched. The bench checks these with full register sweeps against its own model.

// File: rtl/s16m_pkg.sv
// Package s16m_pkg
// Shared constants and the decoded-operation record for the dual-lane
// halfword multiply-accumulate unit. Assumes a 32-bit instruction word
// with 4-bit register fields.
package s16m_pkg;
    localparam int WORD_W   = 32;
    localparam int NUM_REGS = 16;
    localparam int IDX_W    = 4;
    localparam logic [5:0] MAJOR_CLASS = 6'h1C;
    localparam logic [5:0] FUNC_DMAC   = 6'h0A;

    typedef logic [IDX_W-1:0] ridx_t;

    typedef struct packed {
        logic       hit;
        ridx_t      acc_l;
        ridx_t      src_b;
        ridx_t      src_c;
        ridx_t      acc_r;
        logic [1:0] opat;
        logic [1:0] apat;
    } dmac_op_t;
endpackage

// File: rtl/s16m_decode.sv
// Module s16m_decode
// Pure combinational field extraction for the multiply-accumulate
// instruction. Assumes the caller qualifies hit with its own valid strobe.
module s16m_decode
    import s16m_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output dmac_op_t          op
);
    // Split the word into its class match and operand fields.
    always_comb begin
        op.hit   = (word[31:26] == MAJOR_CLASS) && (word[5:0] == FUNC_DMAC);
        op.acc_l = word[9:6];
        op.src_b = word[13:10];
        op.src_c = word[17:14];
        op.acc_r = word[21:18];
        op.opat  = word[23:22];
        op.apat  = word[25:24];
    end
endmodule

// File: rtl/s16m_regbank.sv
// Module s16m_regbank
// Register bank with NRD combinational read ports and NWR write ports.
// Entry 0 is held at zero. When several write ports hit one entry, the
// highest-numbered port wins. Reset is synchronous and active low.
module s16m_regbank #(
    parameter  int DW    = 32,
    parameter  int NREGS = 16,
    parameter  int NRD   = 6,
    parameter  int NWR   = 3,
    localparam int IW    = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] rd_idx  [NRD],
    output logic [DW-1:0] rd_data [NRD],
    input  logic [NWR-1:0] wr_en,
    input  logic [IW-1:0] wr_idx  [NWR],
    input  logic [DW-1:0] wr_data [NWR]
);
    logic [DW-1:0] mem [NREGS];

    // Clear on reset, else apply writes in port order so later ports win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) mem[i] <= '0;
        end else begin
            for (int i = 1; i < NREGS; i++)
                for (int j = 0; j < NWR; j++)
                    if (wr_en[j] && wr_idx[j] == IW'(i)) mem[i] <= wr_data[j];
        end
    end

    // One asynchronous read mux per read port.
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data[p] = mem[rd_idx[p]];
    end

    // Flag write ports whose target is also hit by a later port.
    logic [NWR-1:0] shadowed;
    always_comb begin
        shadowed = '0;
        for (int j = 0; j < NWR; j++)
            for (int k = j + 1; k < NWR; k++)
                if (wr_en[k] && wr_idx[k] == wr_idx[j]) shadowed[j] = 1'b1;
    end

    // R10 R12: an unshadowed write to a nonzero entry is visible next cycle.
    for (genvar j = 0; j < NWR; j++) begin : g_chk
        p_write_lands_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en[j] && wr_idx[j] != '0 && !shadowed[j])
            |=> (mem[$past(wr_idx[j])] == $past(wr_data[j])));
    end
endmodule

// File: rtl/s16m_lane.sv
// Module s16m_lane
// One arithmetic lane: signed HWxHW multiply, sign-extended to DW bits,
// then added to or subtracted from the accumulator with modular wrap.
module s16m_lane #(
    parameter int DW = 32,
    parameter int HW = 16
) (
    input  logic signed [HW-1:0] x,
    input  logic signed [HW-1:0] y,
    input  logic        [DW-1:0] acc,
    input  logic                 sub,
    output logic        [DW-1:0] res
);
    logic signed [2*HW-1:0] prod;
    logic signed [DW-1:0]   prod_x;

    // Form the full-width signed product and its accumulated result.
    always_comb begin
        prod   = x * y;
        prod_x = DW'(prod);
        res    = sub ? (acc - prod_x) : (acc + prod_x);
    end
endmodule

// File: rtl/s16m_lanes.sv
// Module s16m_lanes
// Chooses the halfword pairs for the left and right lanes from the operand
// pattern, chooses add or subtract per lane from the accumulate pattern,
// and instantiates one s16m_lane per lane. Combinational only.
module s16m_lanes #(
    parameter  int DW = 32,
    localparam int HW = DW / 2
) (
    input  logic [DW-1:0] src_b,
    input  logic [DW-1:0] src_c,
    input  logic [DW-1:0] acc_l,
    input  logic [DW-1:0] acc_r,
    input  logic [1:0]    opat,
    input  logic [1:0]    apat,
    input  logic          chk_en,
    output logic [DW-1:0] res_l,
    output logic [DW-1:0] res_r
);
    logic signed [HW-1:0] pick_b [2];
    logic signed [HW-1:0] pick_c [2];
    logic [DW-1:0]        acc_in [2];
    logic [DW-1:0]        res_out[2];
    logic [1:0]           sub_en;

    // Route halves: lane 0 is left, lane 1 is right.
    always_comb begin
        pick_b[0] = opat[0] ? src_b[HW-1:0] : src_b[DW-1:HW];
        pick_c[0] = src_c[DW-1:HW];
        pick_b[1] = opat[1] ? src_b[DW-1:HW] : src_b[HW-1:0];
        pick_c[1] = src_c[HW-1:0];
        sub_en    = {apat[0], apat[1]};
        acc_in[0] = acc_l;
        acc_in[1] = acc_r;
    end

    for (genvar l = 0; l < 2; l++) begin : g_lane
        s16m_lane #(.DW(DW), .HW(HW)) u_lane (
            .x  (pick_b[l]),
            .y  (pick_c[l]),
            .acc(acc_in[l]),
            .sub(sub_en[l]),
            .res(res_out[l])
        );
    end

    assign res_l = res_out[0];
    assign res_r = res_out[1];

    // Independent per-pattern reference used only by the checks below.
    function automatic logic [DW-1:0] lane_ref(input logic [DW-1:0] b, c, acc,
                                               input logic [1:0] op, ap,
                                               input logic right);
        logic signed [DW-1:0] bh, bl, ch, cl, p;
        bh = DW'($signed(b[DW-1:HW]));
        bl = DW'($signed(b[HW-1:0]));
        ch = DW'($signed(c[DW-1:HW]));
        cl = DW'($signed(c[HW-1:0]));
        case ({right, op})
            3'b000, 3'b010: p = bh * ch;
            3'b001, 3'b011: p = bl * ch;
            3'b100, 3'b101: p = bl * cl;
            default:        p = bh * cl;
        endcase
        if (right ? ap[0] : ap[1]) return acc - p;
        return acc + p;
    endfunction

    // R5 R6: both lanes agree with the pattern tables when an op executes.
    always_comb begin
        if (chk_en) begin
            p_left_lane_r5: assert (res_l == lane_ref(src_b, src_c, acc_l, opat, apat, 1'b0));
            p_right_lane_r6: assert (res_r == lane_ref(src_b, src_c, acc_r, opat, apat, 1'b1));
        end
    end
endmodule

// File: rtl/simd16_mac.sv
// Module simd16_mac
// Single-cycle dual-lane signed halfword multiply-accumulate unit with its
// own 16-entry register bank, a direct load port and NPEEK observation
// ports. A recognised word updates the bank at the next edge; done follows
// for one cycle. Assumes a synchronous active-low reset.
module simd16_mac
    import s16m_pkg::*;
#(
    parameter  int NPEEK = 2,
    localparam int DW    = WORD_W,
    localparam int IW    = IDX_W,
    localparam int NRD   = 4 + NPEEK,
    localparam int NWR   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                issue_valid,
    input  logic [WORD_W-1:0]   issue_word,
    output logic                done,
    input  logic                load_en,
    input  logic [IW-1:0]       load_idx,
    input  logic [DW-1:0]       load_data,
    input  logic [NPEEK*IW-1:0] peek_idx,
    output logic [NPEEK*DW-1:0] peek_data
);
    dmac_op_t      op;
    logic          exec;
    logic [IW-1:0] rd_idx  [NRD];
    logic [DW-1:0] rd_data [NRD];
    logic [NWR-1:0] wr_en;
    logic [IW-1:0] wr_idx  [NWR];
    logic [DW-1:0] wr_data [NWR];
    logic [DW-1:0] res_l, res_r;
    logic          done_q;

    s16m_decode u_dec (.word(issue_word), .op(op));

    assign exec = issue_valid && op.hit;

    // Read ports 0..3 serve the instruction, the rest serve observers.
    always_comb begin
        rd_idx[0] = op.acc_l;
        rd_idx[1] = op.src_b;
        rd_idx[2] = op.src_c;
        rd_idx[3] = op.acc_r;
    end

    for (genvar p = 0; p < NPEEK; p++) begin : g_peek
        assign rd_idx[4+p]            = peek_idx[p*IW +: IW];
        assign peek_data[p*DW +: DW]  = rd_data[4+p];
    end

    s16m_lanes #(.DW(DW)) u_lanes (
        .src_b (rd_data[1]),
        .src_c (rd_data[2]),
        .acc_l (rd_data[0]),
        .acc_r (rd_data[3]),
        .opat  (op.opat),
        .apat  (op.apat),
        .chk_en(exec && rst_n),
        .res_l (res_l),
        .res_r (res_r)
    );

    // Write ports in rising priority: load, left lane, right lane.
    always_comb begin
        wr_en      = {exec, exec, load_en};
        wr_idx[0]  = load_idx;
        wr_data[0] = load_data;
        wr_idx[1]  = op.acc_l;
        wr_data[1] = res_l;
        wr_idx[2]  = op.acc_r;
        wr_data[2] = res_r;
    end

    s16m_regbank #(.DW(DW), .NREGS(NUM_REGS), .NRD(NRD), .NWR(NWR)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (rd_idx),
        .rd_data(rd_data),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(wr_data)
    );

    // Completion flag: high for the cycle after an accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= exec;
    end

    assign done = done_q;

    // R2: an accepted word is always followed by done.
    p_done_after_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && op.hit) |=> done);

    // R1: no done follows a cycle without an accepted word.
    p_no_spurious_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_valid && op.hit) |=> !done);
endmodule

// File: tb/sim_simd16_mac.sv
module sim_simd16_mac;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          issue_valid = 1'b0;
    logic [31:0]   issue_word = '0;
    logic          done;
    logic          load_en = 1'b0;
    logic [IW-1:0] load_idx = '0;
    logic [DW-1:0] load_data = '0;
    logic [2*IW-1:0] peek_idx;
    logic [2*DW-1:0] peek_data;

    logic [2*IW-1:0] mon_idx = '0;
    logic [2*IW-1:0] swp_idx = '0;
    logic            swp_active = 1'b0;
    assign peek_idx = swp_active ? swp_idx : mon_idx;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    logic [31:0] model [16];

    typedef struct {
        logic [3:0]  ia;
        logic [31:0] va;
        logic [3:0]  id;
        logic [31:0] vd;
        string       tag;
    } exp_t;
    exp_t sb [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    simd16_mac u0 (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_word(issue_word),
        .done(done), .load_en(load_en), .load_idx(load_idx), .load_data(load_data),
        .peek_idx(peek_idx), .peek_data(peek_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input logic [3:0] a, b, c, d, input logic [1:0] op, ap);
        return {6'h1C, ap, op, d, c, b, a, 6'h0A};
    endfunction

    // Reference model: read all old values first, then write left then right.
    function automatic void model_exec(input logic [3:0] a, b, c, d, input logic [1:0] op, ap);
        int bh, bl, ch, cl, pl, pr;
        logic [31:0] oa, od;
        bh = int'($signed(model[b][31:16]));
        bl = int'($signed(model[b][15:0]));
        ch = int'($signed(model[c][31:16]));
        cl = int'($signed(model[c][15:0]));
        oa = model[a];
        od = model[d];
        pl = (op[0] ? bl : bh) * ch;
        pr = (op[1] ? bh : bl) * cl;
        if (a != 0) model[a] = ap[1] ? oa - 32'(pl) : oa + 32'(pl);
        if (d != 0) model[d] = ap[0] ? od - 32'(pr) : od + 32'(pr);
    endfunction

    task automatic issue(input logic [3:0] a, b, c, d, input logic [1:0] op, ap, input string tag);
        exp_t e;
        @(negedge clk);
        model_exec(a, b, c, d, op, ap);
        e.ia = a; e.va = model[a]; e.id = d; e.vd = model[d]; e.tag = tag;
        sb.push_back(e);
        load_en     = 1'b0;
        issue_valid = 1'b1;
        issue_word  = enc(a, b, c, d, op, ap);
    endtask

    task automatic load(input logic [3:0] idx, input logic [31:0] val);
        @(negedge clk);
        issue_valid = 1'b0;
        load_en     = 1'b1;
        load_idx    = idx;
        load_data   = val;
        if (idx != 0) model[idx] = val;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            issue_valid = 1'b0;
            load_en     = 1'b0;
        end
    endtask

    task automatic sweep(input string tag);
        idle(2);
        swp_active = 1'b1;
        for (int i = 0; i < 16; i += 2) begin
            swp_idx = {4'(i + 1), 4'(i)};
            #1;
            chk(tag, peek_data[31:0], model[i]);
            chk(tag, peek_data[63:32], model[i + 1]);
        end
        swp_active = 1'b0;
    endtask

    task automatic issue_bad(input logic valid, input logic [31:0] w, input string tag);
        @(negedge clk);
        load_en     = 1'b0;
        issue_valid = valid;
        issue_word  = w;
        @(negedge clk);
        issue_valid = 1'b0;
        #1;
        chk(tag, 32'(done), 32'd0);
    endtask

    // Monitor: pops one expected item per done and compares both registers.
    initial begin
        forever begin
            @(negedge clk);
            if (done === 1'b1) begin
                if (sb.size() == 0) begin
                    chk("R2 done without issue", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    mon_idx = {e.id, e.ia};
                    #1;
                    chk(e.tag, peek_data[31:0], e.va);
                    chk(e.tag, peek_data[63:32], e.vd);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R11 done low after reset", 32'(done), 32'd0);
        sweep("R11 bank cleared");

        // R12: load and peek
        load(4'd1, 32'h0003_FFFE);
        load(4'd2, 32'hFFFF_0005);
        load(4'd3, 32'h0000_1000);
        load(4'd4, 32'h0000_0020);
        sweep("R12 load visible");

        // R5 R6 R3: every operand and accumulate pattern, chained
        for (int op = 0; op < 4; op++)
            for (int ap = 0; ap < 4; ap++)
                issue(4'd3, 4'd1, 4'd2, 4'd4, 2'(op), 2'(ap), "R5 R6 R3 pattern");
        sweep("R5 R6 pattern sweep");

        // R2: single pulse
        issue(4'd5, 4'd1, 4'd2, 4'd6, 2'd0, 2'd0, "R2 issue");
        idle(1);
        @(negedge clk);
        #1;
        chk("R2 pulse one cycle", 32'(done), 32'd0);

        // R7: accumulators are also sources
        issue(4'd1, 4'd1, 4'd2, 4'd2, 2'd3, 2'd1, "R7 old values");
        issue(4'd2, 4'd2, 4'd2, 4'd1, 2'd2, 2'd2, "R7 old values");
        sweep("R7 sweep");

        // R10: equal accumulators, right result wins
        issue(4'd5, 4'd1, 4'd2, 4'd5, 2'd0, 2'd1, "R10 same accumulator");
        sweep("R10 sweep");

        // R8: wrap at both limits
        load(4'd1, 32'h0001_0001);
        load(4'd2, 32'h0001_0001);
        load(4'd6, 32'h7FFF_FFFF);
        load(4'd7, 32'h8000_0000);
        issue(4'd6, 4'd1, 4'd2, 4'd7, 2'd0, 2'd1, "R8 wrap");
        idle(2);
        chk("R8 positive wrap", model[6], 32'h8000_0000);
        chk("R8 negative wrap", model[7], 32'h7FFF_FFFF);

        // R4: most negative halves
        load(4'd8, 32'h8000_8000);
        load(4'd9, 32'h0000_0000);
        load(4'd10, 32'h0000_0000);
        issue(4'd9, 4'd8, 4'd8, 4'd10, 2'd0, 2'd0, "R4 signed halves");
        idle(2);
        chk("R4 expected product", model[9], 32'h4000_0000);
        load(4'd11, 32'hFFFF_0002);
        issue(4'd12, 4'd11, 4'd1, 4'd13, 2'd3, 2'd3, "R4 negative half");

        // R9: register zero
        load(4'd0, 32'hDEAD_BEEF);
        issue(4'd0, 4'd1, 4'd8, 4'd0, 2'd0, 2'd0, "R9 write to zero");
        issue(4'd14, 4'd0, 4'd1, 4'd15, 2'd1, 2'd0, "R9 zero source");
        sweep("R9 sweep");

        // R1: ignored words
        issue_bad(1'b1, {6'h00, 20'h12345, 6'h0A}, "R1 wrong class");
        issue_bad(1'b1, {6'h1C, 20'h12345, 6'h08}, "R1 wrong function");
        issue_bad(1'b0, enc(4'd3, 4'd1, 4'd2, 4'd4, 2'd0, 2'd0), "R1 valid low");
        sweep("R1 bank unchanged");

        // R3 R5 R6 R12: mixed random traffic
        for (int n = 0; n < 300; n++) begin
            if (($urandom % 5) == 0)
                load(4'($urandom), $urandom);
            else
                issue(4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom),
                      2'($urandom), 2'($urandom), "R3 R5 R6 random");
        end
        sweep("R3 random sweep");
        chk("R2 every issue completed", 32'(sb.size()), 32'd0);

        // R11: reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) model[i] = '0;
        sweep("R11 second reset");

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule